// File: doc/BRIEF.md
# Multiprocessor Private Region Decoder

This block sits in front of the private register window that a small cluster of up to four CPUs shares. A request carries a 12-bit offset, a read or write flag, write data and the index of the CPU making it. The decoder splits the window into three areas: a few snoop-control registers, the interrupt-controller CPU interfaces, and the timer and watchdog banks. It forwards each access with a CPU index and a local offset. Read data comes back in the same cycle, either from the selected sub-block or from the decoder's own registers.

The interrupt and timer areas each have two ways in. One page always means "the CPU making this request". A run of pages after it addresses one CPU each, explicitly. The snoop-control area holds a single enable bit. It also has a configuration word that is derived from the CPU-count parameter and is not stored. Sub-blocks are assumed to return read data combinationally for the selected location.

Top module: `mp_private_decoder`

## Requirements
- R1: After reset, the enable register reads 0 at offset 0x000 and `scu_enable` is 0.
- R2: A write to offset 0x000 stores only bit 0 of the write data. That bit reads back at bit 0 with all other bits 0, and drives `scu_enable` from the next clock edge.
- R3: Offset 0x004 reads ((2^N)-1)<<4 | (N-1) for N configured CPUs. Offsets 0x008 and 0x00C read 0. Writes to 0x004, 0x008 and 0x00C change no state.
- R4: Offsets 0x100-0x1FF raise `gic_sel` with `gic_cpu` equal to `req_cpu` and `gic_off` equal to offset bits 7:0. `req_rdata` then returns `gic_rdata`.
- R5: Offsets 0x200-0x5FF raise `gic_sel` with `gic_cpu` = (offset-0x200)>>8 and the same local offset and read path as R4.
- R6: Offsets 0x600-0x6FF raise `tmr_sel` with `tmr_inst` = 2*`req_cpu` + offset bit 5 (bit 5 set selects the watchdog) and `tmr_off` = offset bits 3:0. `req_rdata` returns `tmr_rdata`.
- R7: Offsets 0x700-0xAFF raise `tmr_sel` with the CPU taken as (offset-0x700)>>8 and the instance and local offset formed as in R6.
- R8: When the target CPU index of an interrupt or timer access (explicit or same-CPU page) is N or more, no select is raised, `req_rdata` is 0 and `req_err` stays 0.
- R9: An offset of 0xB00 or above, or a snoop-control offset other than 0x000, 0x004, 0x008 or 0x00C, raises `req_err` and reads 0. It forwards nothing and changes no state.
- R10: Without `req_valid`, no select and no error are raised and `req_rdata` is 0. `sub_write` and `sub_wdata` mirror the request's write flag and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Offset within the private window |
| req_cpu | input | 2 | Index of the requesting CPU |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, same cycle |
| req_err | output | 1 | Undecodable access |
| scu_enable | output | 1 | Stored snoop-control enable bit |
| sub_write | output | 1 | Write flag to sub-blocks |
| sub_wdata | output | 32 | Write data to sub-blocks |
| gic_sel | output | 1 | Interrupt CPU interface selected |
| gic_cpu | output | 2 | Interrupt interface CPU index |
| gic_off | output | 8 | Interrupt interface local offset |
| gic_rdata | input | 32 | Interrupt interface read data |
| tmr_sel | output | 1 | Timer/watchdog bank selected |
| tmr_inst | output | 3 | Timer instance, 2*cpu + watchdog bit |
| tmr_off | output | 4 | Timer register offset |
| tmr_rdata | input | 32 | Timer read data |

## Verification
The case that matters most is a bank-range decode that lands on a CPU index that is not fitted. The range match and the validity check then fire together, and the validity check must win. The bench provokes this with a three-CPU build and a full sweep of every offset. The same-CPU pages are visited with each of the four requester indices, so the missing fourth CPU reaches both the explicit pages and the same-CPU pages. At each offset, the bench computes the expected select, index, local offset, read data and error flag arithmetically and compares all of them in the same cycle.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
   localparam int MAX_CPU = 4;
   localparam int CPU_W   = $clog2(MAX_CPU);
   localparam int INST_W  = CPU_W + 1;
   localparam int ADDR_W  = 12;

   typedef enum logic [1:0] {
      RG_SCU = 2'd0,
      RG_GIC = 2'd1,
      RG_TMR = 2'd2,
      RG_BAD = 2'd3
   } region_e;

   function automatic logic [31:0] cfg_word(input int n);
      logic [31:0] mask;
      mask = (32'd1 << n) - 32'd1;
      return (mask << 4) | 32'(n - 1);
   endfunction
endpackage

// File: rtl/mpd_region_decode.sv
module mpd_region_decode
   import mpd_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic [3:0]       page,
   input  logic [CPU_W-1:0] req_cpu,
   output region_e          region,
   output logic [CPU_W-1:0] tgt_cpu,
   output logic             cpu_ok
);
   logic [MAX_CPU-1:0] present;
   logic [3:0]         rel;

   for (genvar i = 0; i < MAX_CPU; i++) begin : g_present
      assign present[i] = (i < NUM_CPU);
   end

   always_comb begin
      rel     = 4'd0;
      region  = RG_BAD;
      tgt_cpu = req_cpu;
      if (page == 4'd0) begin
         region = RG_SCU;
      end else if (page == 4'd1) begin
         region = RG_GIC;
      end else if (page <= 4'd5) begin
         region  = RG_GIC;
         rel     = page - 4'd2;
         tgt_cpu = rel[CPU_W-1:0];
      end else if (page == 4'd6) begin
         region = RG_TMR;
      end else if (page <= 4'd10) begin
         region  = RG_TMR;
         rel     = page - 4'd7;
         tgt_cpu = rel[CPU_W-1:0];
      end
   end

   assign cpu_ok = present[tgt_cpu];
endmodule

// File: rtl/mpd_scu_regs.sv
module mpd_scu_regs
   import mpd_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  logic [7:0]        off,
   input  logic              wbit,
   output logic [DATA_W-1:0] rdata,
   output logic              bad,
   output logic              enable
);
   localparam logic [31:0] CFG = cfg_word(NUM_CPU);

   logic known;
   logic ctrl_q;

   always_comb begin
      known = 1'b1;
      rdata = '0;
      unique case (off)
         8'h00:   rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
         8'h04:   rdata = DATA_W'(CFG);
         8'h08:   rdata = '0;
         8'h0C:   rdata = '0;
         default: known = 1'b0;
      endcase
      if (!acc) rdata = '0;
   end

   assign bad = acc && !known;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ctrl_q <= 1'b0;
      else if (acc && wr && off == 8'h00)   ctrl_q <= wbit;
   end

   assign enable = ctrl_q;

   a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && wr && off == 8'h00) |=> $stable(enable));
   a_r2_load : assert property (@(posedge clk) disable iff (!rst_n)
      (acc && wr && off == 8'h00) |=> enable == $past(wbit));
endmodule

// File: rtl/mpd_route.sv
module mpd_route
   import mpd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  region_e           region,
   input  logic [CPU_W-1:0]  tgt_cpu,
   input  logic              cpu_ok,
   input  logic [7:0]        loc,
   input  logic [DATA_W-1:0] scu_rdata,
   input  logic              scu_bad,
   input  logic [DATA_W-1:0] gic_rdata,
   input  logic [DATA_W-1:0] tmr_rdata,
   output logic              gic_sel,
   output logic [CPU_W-1:0]  gic_cpu,
   output logic [7:0]        gic_off,
   output logic              tmr_sel,
   output logic [INST_W-1:0] tmr_inst,
   output logic [3:0]        tmr_off,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);
   assign gic_sel  = valid && region == RG_GIC && cpu_ok;
   assign tmr_sel  = valid && region == RG_TMR && cpu_ok;
   assign gic_cpu  = tgt_cpu;
   assign gic_off  = loc;
   assign tmr_inst = {tgt_cpu, loc[5]};
   assign tmr_off  = loc[3:0];
   assign err      = valid && (region == RG_BAD || scu_bad);

   always_comb begin
      rdata = '0;
      if (valid) begin
         unique case (region)
            RG_SCU:  rdata = scu_rdata;
            RG_GIC:  rdata = cpu_ok ? gic_rdata : '0;
            RG_TMR:  rdata = cpu_ok ? tmr_rdata : '0;
            default: rdata = '0;
         endcase
      end
   end

   a_r10_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gic_sel, tmr_sel, err}));
   a_r9_err_silent : assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0 && !gic_sel && !tmr_sel));
   a_r8_absent_cpu : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && region != RG_SCU && region != RG_BAD && !cpu_ok)
         |-> (!gic_sel && !tmr_sel && !err && rdata == '0));
   a_r10_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (!gic_sel && !tmr_sel && !err && rdata == '0));
endmodule

// File: rtl/mp_private_decoder.sv
module mp_private_decoder
   import mpd_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [11:0]       req_addr,
   input  logic [1:0]        req_cpu,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] req_rdata,
   output logic              req_err,
   output logic              scu_enable,
   output logic              sub_write,
   output logic [DATA_W-1:0] sub_wdata,
   output logic              gic_sel,
   output logic [1:0]        gic_cpu,
   output logic [7:0]        gic_off,
   input  logic [DATA_W-1:0] gic_rdata,
   output logic              tmr_sel,
   output logic [2:0]        tmr_inst,
   output logic [3:0]        tmr_off,
   input  logic [DATA_W-1:0] tmr_rdata
);
   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu_count
      $error("NUM_CPU must lie in 1..%0d", MAX_CPU);
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8 to hold the configuration word");
   end

   region_e           region;
   logic [CPU_W-1:0]  tgt_cpu;
   logic              cpu_ok;
   logic [DATA_W-1:0] scu_rdata;
   logic              scu_bad;
   logic              scu_acc;

   mpd_region_decode #(.NUM_CPU(NUM_CPU)) u_decode (
      .page    (req_addr[11:8]),
      .req_cpu (req_cpu),
      .region  (region),
      .tgt_cpu (tgt_cpu),
      .cpu_ok  (cpu_ok)
   );

   assign scu_acc = req_valid && region == RG_SCU;

   mpd_scu_regs #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_scu (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (scu_acc),
      .wr     (req_write),
      .off    (req_addr[7:0]),
      .wbit   (req_wdata[0]),
      .rdata  (scu_rdata),
      .bad    (scu_bad),
      .enable (scu_enable)
   );

   mpd_route #(.DATA_W(DATA_W)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (req_valid),
      .region    (region),
      .tgt_cpu   (tgt_cpu),
      .cpu_ok    (cpu_ok),
      .loc       (req_addr[7:0]),
      .scu_rdata (scu_rdata),
      .scu_bad   (scu_bad),
      .gic_rdata (gic_rdata),
      .tmr_rdata (tmr_rdata),
      .gic_sel   (gic_sel),
      .gic_cpu   (gic_cpu),
      .gic_off   (gic_off),
      .tmr_sel   (tmr_sel),
      .tmr_inst  (tmr_inst),
      .tmr_off   (tmr_off),
      .rdata     (req_rdata),
      .err       (req_err)
   );

   assign sub_write = req_write;
   assign sub_wdata = req_wdata;

   a_r9_no_state_change : assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> $stable(scu_enable));
endmodule

// File: tb/mp_private_decoder_bench.sv
module mp_private_decoder_bench;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_cpu = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] req_rdata;
   logic        req_err;
   logic        scu_enable;
   logic        sub_write;
   logic [31:0] sub_wdata;
   logic        gic_sel;
   logic [1:0]  gic_cpu;
   logic [7:0]  gic_off;
   logic [31:0] gic_rdata;
   logic        tmr_sel;
   logic [2:0]  tmr_inst;
   logic [3:0]  tmr_off;
   logic [31:0] tmr_rdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   assign gic_rdata = {16'hC1C0, 6'b0, gic_cpu, gic_off};
   assign tmr_rdata = {16'h7A7A, 9'b0, tmr_inst, tmr_off};

   mp_private_decoder #(.NUM_CPU(N)) u_mp_private_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_cpu(req_cpu), .req_wdata(req_wdata),
      .req_rdata(req_rdata), .req_err(req_err), .scu_enable(scu_enable),
      .sub_write(sub_write), .sub_wdata(sub_wdata), .gic_sel(gic_sel),
      .gic_cpu(gic_cpu), .gic_off(gic_off), .gic_rdata(gic_rdata),
      .tmr_sel(tmr_sel), .tmr_inst(tmr_inst), .tmr_off(tmr_off),
      .tmr_rdata(tmr_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s addr=%h cpu=%0d actual=%h expected=%h",
                  req, req_addr, req_cpu, act, exp);
      end
   endtask

   task automatic drive(input bit v, input bit w, input int a, input int c,
                        input logic [31:0] d);
      @(negedge clk);
      req_valid = v; req_write = w; req_addr = 12'(a);
      req_cpu = 2'(c); req_wdata = d;
      #2;
   endtask

   task automatic sweep_one(input int a, input int c, input bit ctrl);
      string req;
      int page, off, cpu, inst;
      bit e_gic, e_tmr, e_err;
      logic [31:0] e_rd;
      logic [63:0] act, exp;
      page = a >> 8; off = a & 255; cpu = c;
      e_gic = 0; e_tmr = 0; e_err = 0; e_rd = '0; req = "R9";
      if (page == 0) begin
         req = "R3";
         if (off == 0) e_rd = {31'b0, ctrl};
         else if (off == 4) e_rd = (((32'd1 << N) - 1) << 4) | (N - 1);
         else if (off == 8 || off == 12) e_rd = '0;
         else begin e_err = 1; req = "R9"; end
      end else if (page <= 5) begin
         req = (page == 1) ? "R4" : "R5";
         if (page != 1) cpu = page - 2;
         if (cpu < N) begin
            e_gic = 1; e_rd = 32'hC1C00000 | 32'(cpu << 8) | 32'(off);
         end else req = "R8";
      end else if (page <= 10) begin
         req = (page == 6) ? "R6" : "R7";
         if (page != 6) cpu = page - 7;
         inst = cpu * 2 + ((a >> 5) & 1);
         if (cpu < N) begin
            e_tmr = 1; e_rd = 32'h7A7A0000 | 32'(inst << 4) | 32'(a & 15);
         end else req = "R8";
      end else e_err = 1;
      drive(1, 0, a, c, 32'h0);
      act = {req_rdata, 29'b0, gic_sel, tmr_sel, req_err};
      exp = {e_rd, 29'b0, e_gic, e_tmr, e_err};
      if (e_gic) begin
         act[28:19] = {gic_cpu, gic_off};
         exp[28:19] = {2'(cpu), 8'(off)};
      end
      if (e_tmr) begin
         act[28:22] = {tmr_inst, tmr_off};
         exp[28:22] = {3'(cpu * 2 + ((a >> 5) & 1)), 4'(a & 15)};
      end
      check(act == exp, req, act, exp);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      drive(1, 0, 12'h000, 0, 0);
      check(req_rdata == 0 && scu_enable == 0, "R1", {req_rdata, scu_enable}, 0);

      // R2: only bit 0 stored
      drive(1, 1, 12'h000, 1, 32'hFFFF_FFFE);
      drive(0, 0, 0, 0, 0);
      check(scu_enable == 0, "R2", 64'(scu_enable), 0);
      drive(1, 1, 12'h000, 2, 32'hFFFF_FFFF);
      check(scu_enable == 0, "R2", 64'(scu_enable), 0);
      drive(1, 0, 12'h000, 0, 0);
      check(scu_enable == 1 && req_rdata == 32'h1, "R2", 64'(req_rdata), 1);

      // R3: writes to config/status/invalidate change nothing
      drive(1, 1, 12'h004, 0, 32'h0);
      drive(1, 1, 12'h008, 0, 32'h0);
      drive(1, 1, 12'h00C, 0, 32'h0);
      drive(1, 0, 12'h004, 0, 0);
      check(req_rdata == 32'h72 && scu_enable == 1, "R3", 64'(req_rdata), 64'h72);

      // R9: bad writes flag error and leave the enable bit alone
      drive(1, 1, 12'hB00, 0, 32'h0);
      check(req_err == 1 && !gic_sel && !tmr_sel, "R9", 64'(req_err), 1);
      drive(1, 1, 12'h010, 0, 32'h0);
      check(req_err == 1, "R9", 64'(req_err), 1);
      drive(0, 0, 0, 0, 0);
      check(scu_enable == 1, "R9", 64'(scu_enable), 1);

      // R10: write forwarding and idle behaviour
      drive(1, 1, 12'h345, 0, 32'hDEAD_BEEF);
      check(gic_sel && sub_write && sub_wdata == 32'hDEAD_BEEF && gic_cpu == 1,
            "R10", {sub_wdata, 30'b0, gic_cpu}, {32'hDEAD_BEEF, 32'h1});
      drive(0, 1, 12'h7A4, 0, 32'h0);
      check(!gic_sel && !tmr_sel && !req_err && req_rdata == 0, "R10",
            {req_rdata, gic_sel, tmr_sel, req_err}, 0);

      // R3 R4 R5 R6 R7 R8 R9: full offset sweep, requester index cycling
      for (int a = 0; a < 4096; a++) sweep_one(a, a % 4, 1'b1);
      for (int c = 0; c < 4; c++) begin
         sweep_one(12'h1C4, c, 1'b1);
         sweep_one(12'h625, c, 1'b1);
      end

      drive(0, 0, 0, 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule